// File: doc/BRIEF.md
# Debug Mode Switch Sequence Generator

This block sits on the host side of a two-wire debug link and produces the line activity that moves a target's debug port between its serial-wire mode and its boundary-scan mode. A one-cycle start request, qualified by a target-mode select and a recovery flag, launches a fixed three-part frame. The frame is a long stretch of ones, then a 16-bit switch code sent least significant bit first, then a second long stretch of ones. In recovery use the second stretch is dropped.

The debug clock comes from a divider on the system clock and runs only while the frame is in flight. The data line is updated in the same system cycle as each falling debug-clock edge, so it is settled when the target samples on the rising edge. When the last bit has been sent, a done strobe lasts one system cycle. The clock then rests low and the data line rests high.

Top module: `dbg_mode_switch_gen`

## Requirements
- R1: After reset, and before any start, `dclk_o` is 0, `dio_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: The frame opens with `dio_o` at 1 for exactly RUN_LEN rising debug-clock edges (default 56).
- R3: With `to_jtag_i` = 0 at start, the next 16 rising edges carry 16'hE79E, bit 0 first.
- R4: With `to_jtag_i` = 1 at start, the next 16 rising edges carry 16'hE73C, bit 0 first.
- R5: With `recover_i` = 0 at start, the code is followed by `dio_o` at 1 for exactly RUN_LEN more rising edges, and then the frame ends.
- R6: With `recover_i` = 1 at start, the frame ends right after the code, so it has RUN_LEN + 16 rising edges in total.
- R7: `dio_o` changes only in the system cycle in which `dclk_o` falls.
- R8: A RUN_LEN below 50 is treated as 50. With RUN_LEN = 12 and recovery, the frame is 50 ones followed by the code, 66 edges in all.
- R9: A start pulse, or a change of `to_jtag_i` or `recover_i`, while `busy_o` is 1 has no effect on the frame in progress.
- R10: `done_o` is high for exactly one system cycle after the last bit. In that cycle and afterwards `busy_o` is 0, `dclk_o` is 0 and `dio_o` is 1.
- R11: While `busy_o` is 1, each level of `dclk_o` lasts HALF_DIV system cycles, so rising edges are 2*HALF_DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| to_jtag_i | input | 1 | Target mode: 0 serial-wire code, 1 boundary-scan code |
| recover_i | input | 1 | 1 drops the trailing run of ones |
| dclk_o | output | 1 | Debug clock, low when idle |
| dio_o | output | 1 | Debug data/mode line, high when idle |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame strobe |

## Verification
The hardest case to reach from the ports is a start or mode change that arrives while a frame is already running, most of all during the code phase, where a wrongly taken request would reload the code mid-stream. The bench pulses start with the opposite mode and recovery settings twice during one frame: once in the leading run and once inside the code bits. It then checks every sampled bit against the frame it queued at the original start. A second instance with a too-short run length checks the clamp to 50 ones.

// File: rtl/dms_pkg.sv
package dms_pkg;

  localparam int CODE_BITS = 16;
  localparam int MIN_RUN   = 50;

  localparam logic [CODE_BITS-1:0] CODE_TO_SWD  = 16'hE79E;
  localparam logic [CODE_BITS-1:0] CODE_TO_JTAG = 16'hE73C;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_CODE = 2'd2,
    PH_TAIL = 2'd3
  } phase_e;

  function automatic logic [CODE_BITS-1:0] pick_code(input logic to_jtag);
    return to_jtag ? CODE_TO_JTAG : CODE_TO_SWD;
  endfunction

endpackage

// File: rtl/dms_clk_div.sv
module dms_clk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic dclk,
  output logic fall_tick
);

  localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HCW-1:0] LAST = HCW'(HALF - 1);

  logic [HCW-1:0] cnt_q;
  logic           tick;

  assign tick      = en && (cnt_q == LAST);
  assign fall_tick = tick && dclk;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      dclk  <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      dclk  <= ~dclk;
    end else begin
      cnt_q <= cnt_q + HCW'(1);
    end
  end

endmodule

// File: rtl/dms_code_shift.sv
module dms_code_shift
  import dms_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic to_jtag,
  input  logic shift_en,
  output logic next_bit
);

  logic [CODE_BITS-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)          sh_d = pick_code(to_jtag);
    else if (shift_en) sh_d = {1'b1, sh_q[CODE_BITS-1:1]};
  end

  assign next_bit = sh_d[0];

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= sh_d;
  end

endmodule

// File: rtl/dms_seq_ctrl.sv
module dms_seq_ctrl
  import dms_pkg::*;
#(
  parameter int RUN_EFF = 56
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  logic   recover_i,
  input  logic   fall_tick,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   load,
  output logic   done_q
);

  localparam int CW = $clog2(RUN_EFF);
  localparam logic [CW-1:0] LAST_RUN  = CW'(RUN_EFF - 1);
  localparam logic [CW-1:0] LAST_CODE = CW'(CODE_BITS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rec_q, rec_d;
  logic          done_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    rec_d   = rec_q;
    done_d  = 1'b0;
    load    = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          load    = 1'b1;
          phase_d = PH_LEAD;
          cnt_d   = '0;
          rec_d   = recover_i;
        end
      end
      PH_LEAD: begin
        if (fall_tick) begin
          if (cnt_q == LAST_RUN) begin
            phase_d = PH_CODE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      PH_CODE: begin
        if (fall_tick) begin
          if (cnt_q == LAST_CODE) begin
            cnt_d = '0;
            if (rec_q) begin
              phase_d = PH_IDLE;
              done_d  = 1'b1;
            end else begin
              phase_d = PH_TAIL;
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      PH_TAIL: begin
        if (fall_tick) begin
          if (cnt_q == LAST_RUN) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rec_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rec_q   <= rec_d;
      done_q  <= done_d;
    end
  end

endmodule

// File: rtl/dbg_mode_switch_gen.sv
module dbg_mode_switch_gen
  import dms_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int RUN_LEN  = 56
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic to_jtag_i,
  input  logic recover_i,
  output logic dclk_o,
  output logic dio_o,
  output logic busy_o,
  output logic done_o
);

  localparam int RUN_EFF = (RUN_LEN < MIN_RUN) ? MIN_RUN : RUN_LEN;

  phase_e phase_q, phase_d;
  logic   load, fall_tick, next_bit, shift_en, busy;
  logic   dio_q;

  assign busy     = (phase_q != PH_IDLE);
  assign shift_en = fall_tick && (phase_q == PH_CODE);

  dms_clk_div #(.HALF(HALF_DIV)) u_div (
    .clk       (clk),
    .rst       (rst),
    .en        (busy),
    .dclk      (dclk_o),
    .fall_tick (fall_tick)
  );

  dms_seq_ctrl #(.RUN_EFF(RUN_EFF)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .recover_i (recover_i),
    .fall_tick (fall_tick),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .load      (load),
    .done_q    (done_o)
  );

  dms_code_shift u_code (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .to_jtag  (to_jtag_i),
    .shift_en (shift_en),
    .next_bit (next_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) dio_q <= 1'b1;
    else     dio_q <= (phase_d == PH_CODE) ? next_bit : 1'b1;
  end

  assign dio_o  = dio_q;
  assign busy_o = busy;

endmodule

// File: rtl/dms_checker.sv
module dms_checker #(
  parameter int HALF = 2
) (
  input logic clk,
  input logic rst,
  input logic dclk_o,
  input logic dio_o,
  input logic busy_o,
  input logic done_o
);

  logic        p_dclk;
  logic [15:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_dclk <= 1'b0;
      held   <= '0;
    end else begin
      p_dclk <= dclk_o;
      if (!busy_o)              held <= '0;
      else if (dclk_o != p_dclk) held <= 16'd1;
      else                       held <= held + 16'd1;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dclk_o && dio_o && !busy_o && !done_o));

  a_r7_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(dio_o) |-> $fell(dclk_o));

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r10_idle_lines: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !dclk_o && dio_o));

  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  a_r11_half_period: assert property (@(posedge clk) disable iff (rst)
    (busy_o && (dclk_o != p_dclk)) |-> (held == 16'(HALF)));

endmodule

bind dbg_mode_switch_gen dms_checker #(.HALF(HALF_DIV)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .dclk_o (dclk_o),
  .dio_o  (dio_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/dbg_mode_switch_gen_tb.sv
module dbg_mode_switch_gen_tb;

  localparam int DIV = 2;
  localparam int RUN = 56;
  localparam logic [15:0] SWD_CODE  = 16'hE79E;
  localparam logic [15:0] JTAG_CODE = 16'hE73C;

  typedef struct {
    bit    v;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, to_jtag_i = 1'b0, recover_i = 1'b0;
  logic dclk_o, dio_o, busy_o, done_o;
  logic start_c = 1'b0;
  logic dclk_c, dio_c, busy_c, done_c;

  int errs = 0;
  int checks = 0;
  int run_rises = 0;
  int gap = 0;
  logic pd = 1'b0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  dbg_mode_switch_gen #(.HALF_DIV(DIV), .RUN_LEN(RUN)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .to_jtag_i(to_jtag_i),
    .recover_i(recover_i), .dclk_o(dclk_o), .dio_o(dio_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  dbg_mode_switch_gen #(.HALF_DIV(1), .RUN_LEN(12)) u_clamp (
    .clk(clk), .rst(rst), .start_i(start_c), .to_jtag_i(1'b0),
    .recover_i(1'b1), .dclk_o(dclk_c), .dio_o(dio_c),
    .busy_o(busy_c), .done_o(done_c)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: compare each bit seen at a rising debug-clock edge
  always @(negedge clk) begin
    if (!rst) begin
      gap++;
      if (dclk_o && !pd) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6", "extra bit beyond frame", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(dio_o == e.v, e.req, "bit value", int'(dio_o), int'(e.v));
        end
        if (run_rises > 0) chk(gap == 2 * DIV, "R11", "rise spacing", gap, 2 * DIV);
        gap = 0;
        run_rises++;
      end
      pd = dclk_o;
    end
  end

  task automatic push(input bit v, input string req);
    exp_t e;
    e.v = v;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic run_seq(input bit jtag, input bit rec, input bit poke);
    logic [15:0] code;
    int total;
    code = jtag ? JTAG_CODE : SWD_CODE;
    for (int i = 0; i < RUN; i++) push(1'b1, "R2");
    for (int i = 0; i < 16; i++) push(code[i], jtag ? "R4" : "R3");
    if (!rec) for (int i = 0; i < RUN; i++) push(1'b1, "R5");
    total = rec ? RUN + 16 : 2 * RUN + 16;
    run_rises = 0;
    @(negedge clk);
    start_i = 1'b1; to_jtag_i = jtag; recover_i = rec;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      // R9: requests while busy, once in the lead run and once in the code
      repeat (40) @(negedge clk);
      start_i = 1'b1; to_jtag_i = ~jtag; recover_i = ~rec;
      @(negedge clk);
      start_i = 1'b0;
      repeat (200) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "bits left unsent", exp_q.size(), 0);
    chk(run_rises == total, rec ? "R6" : "R5", "frame length", run_rises, total);
    chk(!busy_o, "R10", "busy at done", int'(busy_o), 0);
    chk(!dclk_o, "R10", "dclk at done", int'(dclk_o), 0);
    chk(dio_o, "R10", "dio at done", int'(dio_o), 1);
    @(negedge clk);
    chk(!done_o, "R10", "done width", int'(done_o), 0);
    chk(dio_o && !dclk_o, "R10", "idle lines", int'({dio_o, dclk_o}), 2);
    exp_q.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!dclk_o && dio_o && !busy_o && !done_o, "R1", "in-reset outputs",
        int'({dclk_o, dio_o, busy_o, done_o}), 4);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!dclk_o && dio_o && !busy_o && !done_o, "R1", "post-reset idle",
        int'({dclk_o, dio_o, busy_o, done_o}), 4);

    run_seq(1'b0, 1'b0, 1'b0);
    run_seq(1'b1, 1'b0, 1'b0);
    run_seq(1'b0, 1'b1, 1'b0);
    run_seq(1'b1, 1'b1, 1'b1);
    run_seq(1'b0, 1'b0, 1'b1);

    begin : clamp_run
      int idx;
      logic pc;
      bit e;
      idx = 0;
      pc = 1'b0;
      @(negedge clk);
      start_c = 1'b1;
      @(negedge clk);
      start_c = 1'b0;
      while (!done_c) begin
        @(negedge clk);
        if (dclk_c && !pc) begin
          e = (idx < 50) ? 1'b1 : ((idx < 66) ? SWD_CODE[idx - 50] : 1'b0);
          chk(dio_c == e, "R8", "clamped frame bit", int'(dio_c), int'(e));
          idx++;
        end
        pc = dclk_c;
      end
      chk(idx == 66, "R8", "clamped frame length", idx, 66);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule